// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block searches for the three integer settings of a phase-locked loop: the reference divider M, the feedback multiplier N and the post-divider index PL. It picks the combination whose output frequency lies closest to a requested rate. The reference frequency and the requested rate are both given in kHz. A one-cycle start pulse loads them. Once the search ends, the block returns the chosen settings, the rate they actually give, a one-cycle done pulse and a flag that says whether the match is inexact. It does not program any PLL.

The search runs on a single shared serial divider. It computes a post-divider index window, then walks PL upward. For each PL it walks M upward, and for each M it tries the one or two N values around the ideal quotient. A candidate must respect the comparison-frequency limit, the N limits and the VCO limits. Its error is measured on the rounded post-divided VCO frequency against twice the requested rate. The search ends at once on a zero error. The post-divider table is not monotonic, so the index window may revisit a ratio that an earlier index already used.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, done, inexact, m_out, n_out, pl_out and rate_khz are all zero.
- R2: The post-divider index maps to a divide ratio as follows: 0→1, 1→2, 2→3, 3→4, 4→5, 5→6, 6→8, 7→10, 8→12, 9→16, 10→12, 11→16, 12→20, 13→24, 14→32. Any other index maps to 1. The reported rate is computed with this ratio.
- R3: Let T be twice the requested rate and P = T + floor(T/50). Let the upper VCO bound B be the larger of 2,064,000 and P. The index window runs from rev(clamp(floor(1,000,000/P))) to rev(clamp(ceil(B/P))). Here clamp limits a ratio to the range 1..32, and rev returns the lowest index in 0..13 whose ratio is at least the argument, or 14 if none is. A chosen PL always lies in this window.
- R4: The search walks PL upward through the window. For each PL it walks M upward from 1 to 255 and tries N from floor(T·ratio·M/ref) up to the ceiling of that quotient. The best candidate is replaced only by one with a strictly smaller error, so on a tie the earliest candidate is kept.
- R5: An M for which floor(ref/M) is below 12,000 ends the M walk for that PL. An M for which floor(ref/M) is above 38,000 is skipped. A chosen M always gives floor(ref/M) within 12,000..38,000.
- R6: The M walk for a PL also ends when the floor N value exceeds 255. An N below 8 is skipped. A candidate is accepted only if floor(ref·N/M) lies between 1,000,000 and B, both inclusive.
- R7: A candidate's error is |floor((vco + floor(ratio/2))/ratio) − T|. The search stops at the first zero error. inexact is 0 exactly when the chosen candidate has zero error.
- R8: If no candidate is accepted, the result is M = 255, N = 8, PL = 1, with inexact set to 1.
- R9: rate_khz equals floor(ref·N / (2·M·ratio(PL))) for the returned settings.
- R10: done is high for one cycle at the end of a search. The outputs do not change between that pulse and the next one.
- R11: A start pulse during a search is ignored. The result is that of the search already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a search; ignored while a search runs |
| ref_khz | input | 32 | Reference frequency in kHz, nonzero |
| target_khz | input | 32 | Requested output rate in kHz, nonzero |
| m_out | output | 8 | Chosen reference divider |
| n_out | output | 8 | Chosen feedback multiplier |
| pl_out | output | 4 | Chosen post-divider index |
| rate_khz | output | 32 | Rate achieved by the chosen settings, kHz |
| done | output | 1 | One-cycle pulse when the result is ready |
| inexact | output | 1 | High when no zero-error candidate was found |

## Verification
Common reference clocks from 12,000 to 38,400 kHz are paired with random requested rates, and each result is compared with a search model inside the bench. These runs separate the tie-break order and the window walk from arbitrary choices. A set of directed cases covers the rest. An exact-match case proves the early stop and a clear inexact flag. A 38,400 kHz reference forces M = 1 to be skipped. An 11,000 kHz reference accepts nothing and so yields the default settings. A very high requested rate pushes the upper VCO bound beyond its nominal maximum. Further directed checks cover a start pulse in mid-search and outputs held after the done pulse.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

   localparam int unsigned PL_COUNT = 15;
   localparam int unsigned PL_IDX_W = 4;

   typedef enum logic [3:0] {
      S_IDLE, S_PROV, S_HI, S_LO, S_PLTOP, S_MTOP,
      S_NDIV, S_NTOP, S_VCO, S_ERR, S_FIN, S_RATE
   } srch_state_t;

   // post-divider index to divide ratio; out-of-range indices give 1
   function automatic int unsigned idx_ratio(input int unsigned idx);
      case (idx)
         0:  idx_ratio = 1;
         1:  idx_ratio = 2;
         2:  idx_ratio = 3;
         3:  idx_ratio = 4;
         4:  idx_ratio = 5;
         5:  idx_ratio = 6;
         6:  idx_ratio = 8;
         7:  idx_ratio = 10;
         8:  idx_ratio = 12;
         9:  idx_ratio = 16;
         10: idx_ratio = 12;
         11: idx_ratio = 16;
         12: idx_ratio = 20;
         13: idx_ratio = 24;
         14: idx_ratio = 32;
         default: idx_ratio = 1;
      endcase
   endfunction

endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
   parameter int unsigned W = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         fin,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   localparam int unsigned CNT_W = $clog2(W + 1);

   logic [W-1:0]     acc;
   logic [W-1:0]     qr;
   logic [W-1:0]     dd;
   logic [CNT_W-1:0] cnt;
   logic             active;
   logic [W:0]       trial;

   assign trial = {acc, qr[W-1]};
   assign quo   = qr;
   assign rem   = acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         qr     <= '0;
         dd     <= '0;
         cnt    <= '0;
         active <= 1'b0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            acc    <= '0;
            qr     <= num;
            dd     <= den;
            cnt    <= CNT_W'(W);
            active <= 1'b1;
         end else if (active) begin
            if (trial >= {1'b0, dd}) begin
               acc <= W'(trial - {1'b0, dd});
               qr  <= {qr[W-2:0], 1'b1};
            end else begin
               acc <= trial[W-1:0];
               qr  <= {qr[W-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
               active <= 1'b0;
               fin    <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pll_ratio_to_index.sv
module pll_ratio_to_index
   import pll_search_pkg::*;
#(
   parameter int unsigned RATIO_W = 6,
   parameter int unsigned IDX_W   = PL_IDX_W
) (
   input  logic [RATIO_W-1:0] ratio,
   output logic [IDX_W-1:0]   idx
);
   // lowest index in 0..PL_COUNT-2 whose ratio reaches the request
   always_comb begin
      idx = IDX_W'(PL_COUNT - 1);
      for (int k = PL_COUNT - 2; k >= 0; k--) begin
         if (idx_ratio(k) >= 32'(ratio))
            idx = IDX_W'(k);
      end
   end
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
   import pll_search_pkg::*;
#(
   parameter int unsigned FREQ_W    = 32,
   parameter int unsigned M_W       = 8,
   parameter int unsigned N_W       = 8,
   parameter int unsigned M_MIN     = 1,
   parameter int unsigned M_MAX     = 255,
   parameter int unsigned N_MIN     = 8,
   parameter int unsigned N_MAX     = 255,
   parameter int unsigned VCO_MIN   = 1000000,
   parameter int unsigned VCO_MAX   = 2064000,
   parameter int unsigned U_MIN     = 12000,
   parameter int unsigned U_MAX     = 38000,
   parameter int unsigned DIV_MIN   = 1,
   parameter int unsigned DIV_MAX   = 32,
   parameter int unsigned MARGIN    = 50,
   parameter int unsigned DEF_PL    = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [FREQ_W-1:0]   ref_khz,
   input  logic [FREQ_W-1:0]   target_khz,
   output logic [M_W-1:0]      m_out,
   output logic [N_W-1:0]      n_out,
   output logic [PL_IDX_W-1:0] pl_out,
   output logic [FREQ_W-1:0]   rate_khz,
   output logic                done,
   output logic                inexact
);
   localparam int unsigned RATIO_W = $clog2(DIV_MAX + 1);
   localparam int unsigned MN_W    = (M_W > N_W) ? M_W : N_W;
   localparam int unsigned WIDE    = FREQ_W + RATIO_W + MN_W + 2;
   localparam int unsigned PLC_W   = PL_IDX_W + 1;

   localparam logic [WIDE-1:0] K_VCO_MIN = WIDE'(VCO_MIN);
   localparam logic [WIDE-1:0] K_VCO_MAX = WIDE'(VCO_MAX);
   localparam logic [WIDE-1:0] K_U_MIN   = WIDE'(U_MIN);
   localparam logic [WIDE-1:0] K_U_OVER  = WIDE'(U_MAX + 1);
   localparam logic [WIDE-1:0] K_DIV_MIN = WIDE'(DIV_MIN);
   localparam logic [WIDE-1:0] K_DIV_MAX = WIDE'(DIV_MAX);
   localparam logic [WIDE-1:0] K_N_MAX   = WIDE'(N_MAX);

   if (M_MAX >= (1 << M_W)) begin : g_bad_m
      $error("M_MAX does not fit in M_W bits");
   end
   if (N_MAX >= (1 << N_W)) begin : g_bad_n
      $error("N_MAX does not fit in N_W bits");
   end
   if (M_MIN < 1 || N_MIN > N_MAX || U_MIN > U_MAX || VCO_MIN >= VCO_MAX) begin : g_bad_lim
      $error("inconsistent search limits");
   end
   if (DIV_MIN < 1 || DIV_MAX < DIV_MIN || DEF_PL >= PL_COUNT) begin : g_bad_div
      $error("inconsistent post-divider limits");
   end

   srch_state_t          st;
   logic [FREQ_W-1:0]    ref_q;
   logic [WIDE-1:0]      tgt2, tvco, vmax;
   logic [PL_IDX_W-1:0]  hi_idx;
   logic [PLC_W-1:0]     pl_idx;
   logic [M_W:0]         m_cnt;
   logic [N_W:0]         n_cnt, n_hi;
   logic [M_W-1:0]       best_m;
   logic [N_W-1:0]       best_n;
   logic [PL_IDX_W-1:0]  best_pl;
   logic [WIDE-1:0]      best_err;
   logic                 busy;

   logic                 div_go, div_fin;
   logic [WIDE-1:0]      div_num, div_den, div_quo, div_rem;

   logic [WIDE-1:0]      prov_sum, vmax_c, ratio_w, best_ratio_w, ref_w, m_w, err_c;
   logic [RATIO_W-1:0]   ratio_clamped;
   logic [PL_IDX_W-1:0]  mapped_idx;

   assign busy         = (st != S_IDLE);
   assign prov_sum     = tgt2 + div_quo;
   assign vmax_c       = (prov_sum > K_VCO_MAX) ? prov_sum : K_VCO_MAX;
   assign ratio_w      = WIDE'(idx_ratio(32'(pl_idx)));
   assign best_ratio_w = WIDE'(idx_ratio(32'(best_pl)));
   assign ref_w        = WIDE'(ref_q);
   assign m_w          = WIDE'(m_cnt);
   assign err_c        = (div_quo >= tgt2) ? (div_quo - tgt2) : (tgt2 - div_quo);

   always_comb begin
      if (div_quo > K_DIV_MAX)
         ratio_clamped = RATIO_W'(DIV_MAX);
      else if (div_quo < K_DIV_MIN)
         ratio_clamped = RATIO_W'(DIV_MIN);
      else
         ratio_clamped = div_quo[RATIO_W-1:0];
   end

   pll_seq_div #(.W(WIDE)) u_div (
      .clk (clk), .rst_n (rst_n), .go (div_go), .num (div_num), .den (div_den),
      .fin (div_fin), .quo (div_quo), .rem (div_rem)
   );

   pll_ratio_to_index #(.RATIO_W(RATIO_W), .IDX_W(PL_IDX_W)) u_rev (
      .ratio (ratio_clamped), .idx (mapped_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         ref_q    <= '0;
         tgt2     <= '0;
         tvco     <= '0;
         vmax     <= '0;
         hi_idx   <= '0;
         pl_idx   <= '0;
         m_cnt    <= '0;
         n_cnt    <= '0;
         n_hi     <= '0;
         best_m   <= '0;
         best_n   <= '0;
         best_pl  <= '0;
         best_err <= '0;
         div_go   <= 1'b0;
         div_num  <= '0;
         div_den  <= '0;
         m_out    <= '0;
         n_out    <= '0;
         pl_out   <= '0;
         rate_khz <= '0;
         done     <= 1'b0;
         inexact  <= 1'b0;
      end else begin
         div_go <= 1'b0;
         done   <= 1'b0;
         case (st)
            S_IDLE: if (start) begin
               ref_q    <= ref_khz;
               tgt2     <= WIDE'(target_khz) << 1;
               div_num  <= WIDE'(target_khz) << 1;
               div_den  <= WIDE'(MARGIN);
               div_go   <= 1'b1;
               best_m   <= M_W'(M_MAX);
               best_n   <= N_W'(N_MIN);
               best_pl  <= PL_IDX_W'(DEF_PL);
               best_err <= '1;
               st       <= S_PROV;
            end
            S_PROV: if (div_fin) begin
               tvco    <= prov_sum;
               vmax    <= vmax_c;
               div_num <= vmax_c + prov_sum - 1'b1;
               div_den <= prov_sum;
               div_go  <= 1'b1;
               st      <= S_HI;
            end
            S_HI: if (div_fin) begin
               hi_idx  <= mapped_idx;
               div_num <= K_VCO_MIN;
               div_den <= tvco;
               div_go  <= 1'b1;
               st      <= S_LO;
            end
            S_LO: if (div_fin) begin
               pl_idx <= PLC_W'(mapped_idx);
               st     <= S_PLTOP;
            end
            S_PLTOP: begin
               if (pl_idx > PLC_W'(hi_idx)) begin
                  st <= S_FIN;
               end else begin
                  tvco  <= tgt2 * ratio_w;
                  m_cnt <= (M_W + 1)'(M_MIN);
                  st    <= S_MTOP;
               end
            end
            S_MTOP: begin
               if (m_cnt > (M_W + 1)'(M_MAX) || ref_w < K_U_MIN * m_w) begin
                  pl_idx <= pl_idx + 1'b1;
                  st     <= S_PLTOP;
               end else if (ref_w >= K_U_OVER * m_w) begin
                  m_cnt <= m_cnt + 1'b1;
               end else begin
                  div_num <= tvco * m_w;
                  div_den <= ref_w;
                  div_go  <= 1'b1;
                  st      <= S_NDIV;
               end
            end
            S_NDIV: if (div_fin) begin
               if (div_quo > K_N_MAX) begin
                  pl_idx <= pl_idx + 1'b1;
                  st     <= S_PLTOP;
               end else begin
                  n_cnt <= (N_W + 1)'(div_quo);
                  n_hi  <= (N_W + 1)'(div_quo) + ((div_rem != '0) ? 1'b1 : 1'b0);
                  st    <= S_NTOP;
               end
            end
            S_NTOP: begin
               if (n_cnt > n_hi) begin
                  m_cnt <= m_cnt + 1'b1;
                  st    <= S_MTOP;
               end else if (n_cnt < (N_W + 1)'(N_MIN)) begin
                  n_cnt <= n_cnt + 1'b1;
               end else if (n_cnt > (N_W + 1)'(N_MAX)) begin
                  m_cnt <= m_cnt + 1'b1;
                  st    <= S_MTOP;
               end else begin
                  div_num <= ref_w * WIDE'(n_cnt);
                  div_den <= m_w;
                  div_go  <= 1'b1;
                  st      <= S_VCO;
               end
            end
            S_VCO: if (div_fin) begin
               if (div_quo >= K_VCO_MIN && div_quo <= vmax) begin
                  div_num <= div_quo + (ratio_w >> 1);
                  div_den <= ratio_w;
                  div_go  <= 1'b1;
                  st      <= S_ERR;
               end else begin
                  n_cnt <= n_cnt + 1'b1;
                  st    <= S_NTOP;
               end
            end
            S_ERR: if (div_fin) begin
               if (err_c < best_err) begin
                  best_err <= err_c;
                  best_m   <= m_cnt[M_W-1:0];
                  best_n   <= n_cnt[N_W-1:0];
                  best_pl  <= pl_idx[PL_IDX_W-1:0];
               end
               if (err_c == '0) begin
                  st <= S_FIN;
               end else begin
                  n_cnt <= n_cnt + 1'b1;
                  st    <= S_NTOP;
               end
            end
            S_FIN: begin
               div_num <= ref_w * WIDE'(best_n);
               div_den <= (WIDE'(best_m) * best_ratio_w) << 1;
               div_go  <= 1'b1;
               st      <= S_RATE;
            end
            S_RATE: if (div_fin) begin
               m_out    <= best_m;
               n_out    <= best_n;
               pl_out   <= best_pl;
               rate_khz <= (|div_quo[WIDE-1:FREQ_W]) ? '1 : div_quo[FREQ_W-1:0];
               inexact  <= (best_err != '0);
               done     <= 1'b1;
               st       <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pll_coef_search_chk.sv
module pll_coef_search_chk #(
   parameter int unsigned FREQ_W   = 32,
   parameter int unsigned M_W      = 8,
   parameter int unsigned N_W      = 8,
   parameter int unsigned PL_W     = 4,
   parameter int unsigned M_MIN    = 1,
   parameter int unsigned M_MAX    = 255,
   parameter int unsigned N_MIN    = 8,
   parameter int unsigned N_MAX    = 255,
   parameter int unsigned PL_LIMIT = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [M_W-1:0]    m_out,
   input logic [N_W-1:0]    n_out,
   input logic [PL_W-1:0]   pl_out,
   input logic [FREQ_W-1:0] rate_khz,
   input logic              inexact
);
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({m_out, n_out, pl_out, rate_khz, inexact})); // R10

   AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R10

   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R11

   AST_COEF_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (32'(m_out) >= M_MIN && 32'(m_out) <= M_MAX &&
                32'(n_out) >= N_MIN && 32'(n_out) <= N_MAX &&
                32'(pl_out) < PL_LIMIT)); // R6
endmodule

bind pll_coef_search pll_coef_search_chk #(
   .FREQ_W (FREQ_W), .M_W (M_W), .N_W (N_W), .PL_W (pll_search_pkg::PL_IDX_W),
   .M_MIN (M_MIN), .M_MAX (M_MAX), .N_MIN (N_MIN), .N_MAX (N_MAX),
   .PL_LIMIT (pll_search_pkg::PL_COUNT)
) u_chk (
   .clk (clk), .rst_n (rst_n), .start (start), .busy (busy), .done (done),
   .m_out (m_out), .n_out (n_out), .pl_out (pl_out), .rate_khz (rate_khz),
   .inexact (inexact)
);

// File: tb/pll_coef_search_test.sv
module pll_coef_search_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] ref_khz = '0;
   logic [31:0] target_khz = '0;
   logic [7:0]  m_out, n_out;
   logic [3:0]  pl_out;
   logic [31:0] rate_khz;
   logic        done, inexact;

   int n_checks = 0;
   int n_fail   = 0;
   bit hung     = 1'b0;
   int cycles   = 0;

   localparam int WATCHDOG = 190000;

   pll_coef_search uut (
      .clk (clk), .rst_n (rst_n), .start (start), .ref_khz (ref_khz),
      .target_khz (target_khz), .m_out (m_out), .n_out (n_out),
      .pl_out (pl_out), .rate_khz (rate_khz), .done (done), .inexact (inexact)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cycles <= cycles + 1;

   function automatic longint ratio_tb(input longint i);
      case (i)
         0: return 1;   1: return 2;   2: return 3;   3: return 4;
         4: return 5;   5: return 6;   6: return 8;   7: return 10;
         8: return 12;  9: return 16;  10: return 12; 11: return 16;
         12: return 20; 13: return 24; 14: return 32;
         default: return 1;
      endcase
   endfunction

   function automatic longint rev_tb(input longint r);
      longint c;
      c = (r > 32) ? 32 : ((r < 1) ? 1 : r);
      for (int k = 0; k < 14; k++)
         if (ratio_tb(k) >= c) return k;
      return 14;
   endfunction

   // expected result from the requirement rules
   task automatic model(input longint rf, input longint tg,
                        output longint bm, output longint bn, output longint bp,
                        output longint rate, output bit inex, output bit acc,
                        output longint lo, output longint hi, output longint vmax);
      longint t2, pv, tvp, n, n2, v, dv, lw, d, bd;
      bit found;
      t2 = 2 * tg;
      pv = t2 + t2 / 50;
      vmax = (pv > 2064000) ? pv : 2064000;
      hi = rev_tb((vmax + pv - 1) / pv);
      lo = rev_tb(1000000 / pv);
      bd = 64'h7fffffffffffffff;
      bm = 255; bn = 8; bp = 1; found = 0; acc = 0;
      for (longint p = lo; p <= hi; p++) begin
         tvp = t2 * ratio_tb(p);
         for (longint m = 1; m <= 255; m++) begin
            if (rf / m < 12000) break;
            if (rf / m > 38000) continue;
            n  = tvp * m / rf;
            n2 = (tvp * m + rf - 1) / rf;
            if (n > 255) break;
            for (; n <= n2; n++) begin
               if (n < 8) continue;
               if (n > 255) break;
               v = rf * n / m;
               if (v >= 1000000 && v <= vmax) begin
                  dv = ratio_tb(p);
                  lw = (v + dv / 2) / dv;
                  d  = (lw > t2) ? lw - t2 : t2 - lw;
                  acc = 1;
                  if (d < bd) begin
                     bd = d; bm = m; bn = n; bp = p;
                     if (d == 0) begin found = 1; break; end
                  end
               end
            end
            if (found) break;
         end
         if (found) break;
      end
      inex = (bd != 0);
      rate = rf * bn / (bm * ratio_tb(bp)) / 2;
   endtask

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_done();
      while (!done && !hung) begin
         @(negedge clk);
         if (cycles > WATCHDOG) hung = 1'b1;
      end
   endtask

   task automatic run(input longint rf, input longint tg, input bit poke);
      longint em, en, ep, er, lo, hi, vmax, vco;
      bit ei, acc;
      if (hung) return;
      model(rf, tg, em, en, ep, er, ei, acc, lo, hi, vmax);
      @(negedge clk);
      ref_khz = 32'(rf); target_khz = 32'(tg); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (8) @(negedge clk);
         ref_khz = 32'd19200; target_khz = 32'd333333; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait_done();
      if (hung) return;
      chk(m_out == 8'(em), poke ? "R11 m" : "R4 m", m_out, em);
      chk(n_out == 8'(en), poke ? "R11 n" : "R4 n", n_out, en);
      chk(pl_out == 4'(ep), "R4 pl", pl_out, ep);
      chk(rate_khz == 32'(er), "R9 rate", rate_khz, er);
      chk(inexact == ei, "R7 inexact", inexact, ei);
      chk(longint'(rate_khz) == rf * n_out / (2 * m_out * ratio_tb(pl_out)),
          "R2 ratio table", rate_khz, rf * n_out / (2 * m_out * ratio_tb(pl_out)));
      if (acc) begin
         vco = rf * n_out / (m_out == 0 ? 1 : m_out);
         chk(pl_out >= lo && pl_out <= hi, "R3 pl window", pl_out, lo);
         chk(rf / m_out >= 12000 && rf / m_out <= 38000, "R5 comparison freq", rf / m_out, 12000);
         chk(vco >= 1000000 && vco <= vmax && n_out >= 8, "R6 vco bounds", vco, vmax);
      end
   endtask

   initial begin
      int unsigned seed;
      longint refs [5] = '{12000, 12800, 13000, 19200, 38400};
      logic [7:0] hm, hn;
      logic [31:0] hr;
      seed = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done == 1'b0 && inexact == 1'b0, "R1 flags", {done, inexact}, 0);
      chk(m_out == 0 && n_out == 0 && pl_out == 0 && rate_khz == 0, "R1 coefs",
          rate_khz, 0);
      rst_n = 1'b1;

      // exact match: 12000 ref, 600000 target -> M=1 N=100 PL=0
      run(12000, 600000, 1'b0);
      chk(inexact == 1'b0 && m_out == 1 && n_out == 100 && pl_out == 0, "R7 exact stop",
          {m_out, n_out, pl_out}, {8'd1, 8'd100, 4'd0});
      // 38400 ref: M=1 over the comparison limit is skipped
      run(38400, 500000, 1'b0);
      chk(m_out != 1, "R5 skip M=1", m_out, 2);
      // nothing accepted -> defaults
      run(11000, 400000, 1'b0);
      chk(m_out == 255 && n_out == 8 && pl_out == 1 && inexact == 1'b1, "R8 defaults",
          {m_out, n_out, pl_out}, {8'd255, 8'd8, 4'd1});
      chk(rate_khz == 86, "R8 default rate", rate_khz, 86);
      // very high target widens the upper VCO bound
      run(12000, 1100000, 1'b0);
      run(19200, 72000, 1'b0);
      run(13000, 852000, 1'b0);
      // start during search is ignored
      run(12800, 540000, 1'b1);

      // outputs held after done
      if (!hung) begin
         hm = m_out; hn = n_out; hr = rate_khz;
         repeat (20) @(negedge clk);
         chk(m_out == hm && n_out == hn && rate_khz == hr && done == 1'b0, "R10 hold",
             rate_khz, hr);
      end

      for (int i = 0; i < 16; i++) begin
         longint rf, tg;
         if (i % 2 == 0) rf = refs[$urandom_range(4, 0)];
         else rf = longint'($urandom_range(40000, 12000));
         tg = longint'($urandom_range(1000000, 100000));
         run(rf, tg, 1'b0);
      end

      if (hung) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      end
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule